// File: doc/BRIEF.md
# One-Cycle Variable Shifter with Upper-Byte Immediate Load

This block is the shift path of a small integer datapath. It moves a word taken from the first register read port left or right by any distance from zero up to one less than the word width. The distance comes from the low bits of the second read port. A direction input picks the side. A fill input decides whether a right shift brings in zeros or copies of the sign bit. The work is done by one layer of two-way multiplexers per bit of the distance, so every shift takes the same time.

A second mode serves constant loading. When the immediate-select input is high, the block ignores the word and the distance. It places the immediate in the upper half of the result and clears the lower half. Both modes drive one registered result port, which the writeback logic can read one clock after the operands are presented.

Top module: `shf_unit`

## Requirements
- R1: While `rstN` is low, `result` is cleared to zero at each rising clock edge.
- R2: Only bits 3..0 of `busB` set the shift distance (for the default 16-bit width). Bits 15..4 of `busB` have no effect on `result`.
- R3: With `immSel`=0 and `shiftRight`=0, `result` is `busA` moved left by the distance, with zeros in the vacated low bits. This holds for either value of `arithFill`.
- R4: With `immSel`=0, `shiftRight`=1 and `arithFill`=0, `result` is `busA` moved right by the distance, with zeros in the vacated high bits.
- R5: With `immSel`=0, `shiftRight`=1 and `arithFill`=1, `result` is `busA` moved right by the distance, with copies of `busA` bit 15 in the vacated high bits.
- R6: A distance of zero returns `busA` unchanged, in every direction and fill setting.
- R7: With `immSel`=1, `result` equals `immVal` in bits 15..8 and zero in bits 7..0 (for example, `immVal`=0x07 gives 0x0700). `busA`, `busB`, `shiftRight` and `arithFill` have no effect.
- R8: `result` shows the outcome for the inputs sampled at a rising clock edge, starting at that edge, and holds it until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register loads on the rising edge |
| rstN | input | 1 | Active-low synchronous reset of the result register |
| busA | input | DATA_W (16) | Word to be shifted |
| busB | input | DATA_W (16) | Second operand; its low AMT_W bits give the distance |
| shiftRight | input | 1 | 0 shifts left, 1 shifts right |
| arithFill | input | 1 | For right shifts: 0 fills with zeros, 1 with the sign bit |
| immSel | input | 1 | 1 selects the upper-immediate load instead of a shift |
| immVal | input | DATA_W/2 (8) | Immediate placed in the upper half of the result |
| result | output | DATA_W (16) | Registered shift or load result |

## Verification
The bench uses the default width of 16. This gives four multiplexer layers and a four-bit distance, small enough to sweep every distance from 0 to 15 in each of the three shift modes over several data patterns. Those patterns include words with bit 15 set and clear, so sign filling and zero filling are told apart. At this width the upper-immediate path places a full byte, which lets the bench check that both halves land in the right place. With garbage on the upper bits of `busB`, the bench shows that only the low four bits reach the multiplexer layers.

// File: rtl/shf_pkg.sv
package shf_pkg;

  // Strobes passed from the mode decoder to the shifting datapath
  typedef struct packed {
    logic mirror;     // reverse bit order around the right-shift core (left shift)
    logic signFill;   // feed the operand sign bit into vacated positions
    logic loadUpper;  // bypass shifting, place immediate in the upper half
  } shfStrobe_t;

endpackage

// File: rtl/shf_ctrl.sv
module shf_ctrl
  import shf_pkg::*;
(
  input  logic       shiftRight,
  input  logic       arithFill,
  input  logic       immSel,
  output shfStrobe_t strobe
);

  always_comb begin
    strobe.loadUpper = immSel;
    strobe.mirror    = ~immSel & ~shiftRight;
    // sign filling only makes sense when moving toward the low end
    strobe.signFill  = ~immSel & shiftRight & arithFill;
  end

endmodule

// File: rtl/shf_datapath.sv
module shf_datapath
  import shf_pkg::*;
#(
  parameter  int DATA_W = 16,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int IMM_W  = DATA_W / 2
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [AMT_W-1:0]  amt,
  input  logic [IMM_W-1:0]  imm,
  input  shfStrobe_t        strobe,
  output logic [DATA_W-1:0] shiftOut
);

  localparam int LOW_W = DATA_W - IMM_W;

  function automatic logic [DATA_W-1:0] flipBits(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic [DATA_W-1:0] coreIn;
  logic [DATA_W-1:0] coreOut;
  logic [DATA_W-1:0] shifted;
  logic              fillBit;
  logic [DATA_W-1:0] layer [0:AMT_W];

  always_comb begin
    coreIn  = strobe.mirror ? flipBits(opA) : opA;
    fillBit = strobe.signFill & opA[DATA_W-1];
  end

  assign layer[0] = coreIn;

  // One mux layer per distance bit; layer s moves by 2**s toward bit 0
  for (genvar s = 0; s < AMT_W; s++) begin : g_layer
    localparam int SH = 1 << s;
    assign layer[s+1] = amt[s] ? {{SH{fillBit}}, layer[s][DATA_W-1:SH]} : layer[s];
  end

  assign coreOut = layer[AMT_W];

  always_comb begin
    shifted  = strobe.mirror ? flipBits(coreOut) : coreOut;
    shiftOut = strobe.loadUpper ? {imm, {LOW_W{1'b0}}} : shifted;
  end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
  import shf_pkg::*;
#(
  parameter  int DATA_W = 16,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int IMM_W  = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busA,
  input  logic [DATA_W-1:0] busB,
  input  logic              shiftRight,
  input  logic              arithFill,
  input  logic              immSel,
  input  logic [IMM_W-1:0]  immVal,
  output logic [DATA_W-1:0] result
);

  shfStrobe_t        strobe;
  logic [DATA_W-1:0] nextResult;

  shf_ctrl i_ctrl (
    .shiftRight (shiftRight),
    .arithFill  (arithFill),
    .immSel     (immSel),
    .strobe     (strobe)
  );

  shf_datapath #(.DATA_W(DATA_W)) i_dp (
    .opA      (busA),
    .amt      (busB[AMT_W-1:0]),
    .imm      (immVal),
    .strobe   (strobe),
    .shiftOut (nextResult)
  );

  always_ff @(posedge clk) begin
    if (!rstN) result <= '0;
    else       result <= nextResult;
  end

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
  parameter  int DATA_W = 16,
  localparam int AMT_W  = $clog2(DATA_W),
  localparam int IMM_W  = DATA_W / 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] busA,
  input logic [DATA_W-1:0] busB,
  input logic              shiftRight,
  input logic              arithFill,
  input logic              immSel,
  input logic [IMM_W-1:0]  immVal,
  input logic [DATA_W-1:0] result
);

  localparam int LOW_W = DATA_W - IMM_W;

  logic              pastValid;
  logic [DATA_W-1:0] prevA;
  logic [AMT_W-1:0]  prevAmt;
  logic              prevRight;
  logic              prevArith;
  logic              prevImmSel;
  logic [IMM_W-1:0]  prevImm;
  logic [DATA_W-1:0] lowMask;
  logic [DATA_W-1:0] highMask;

  always_ff @(posedge clk) begin
    pastValid  <= rstN;
    prevA      <= busA;
    prevAmt    <= busB[AMT_W-1:0];
    prevRight  <= shiftRight;
    prevArith  <= arithFill;
    prevImmSel <= immSel;
    prevImm    <= immVal;
  end

  always_comb begin
    lowMask  = (DATA_W'(1) << prevAmt) - DATA_W'(1);
    highMask = ~({DATA_W{1'b1}} >> prevAmt);
  end

  p_upper_load_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && prevImmSel) |-> result == {prevImm, {LOW_W{1'b0}}});

  p_zero_dist_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !prevImmSel && prevAmt == '0) |-> result == prevA);

  p_left_zero_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !prevImmSel && !prevRight) |-> (result & lowMask) == '0);

  p_logical_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !prevImmSel && prevRight && !prevArith) |-> (result & highMask) == '0);

  p_sign_fill_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !prevImmSel && prevRight && prevArith)
      |-> (result & highMask) == (prevA[DATA_W-1] ? highMask : '0));

endmodule

bind shf_unit shf_unit_chk #(.DATA_W(DATA_W)) i_shf_unit_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busA       (busA),
  .busB       (busB),
  .shiftRight (shiftRight),
  .arithFill  (arithFill),
  .immSel     (immSel),
  .immVal     (immVal),
  .result     (result)
);

// File: tb/test_shf_unit.sv
`timescale 1ns/1ps
module test_shf_unit;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] busA = '0;
  logic [W-1:0] busB = '0;
  logic         shiftRight = 1'b0;
  logic         arithFill = 1'b0;
  logic         immSel = 1'b0;
  logic [7:0]   immVal = '0;
  logic [W-1:0] result;

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  shf_unit #(.DATA_W(W)) i_shf_unit (
    .clk(clk), .rstN(rstN), .busA(busA), .busB(busB),
    .shiftRight(shiftRight), .arithFill(arithFill),
    .immSel(immSel), .immVal(immVal), .result(result)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    nVec++;
    if (result !== exp) begin
      nBad++;
      $display("FAIL %s: result=%h expected=%h", req, result, exp);
    end
  endtask

  // drive on the falling edge, capture on the rising edge, sample 1 ns later
  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic rt, input logic ar, input logic is,
                       input logic [7:0] iv);
    @(negedge clk);
    busA = a; busB = b; shiftRight = rt; arithFill = ar; immSel = is; immVal = iv;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [W-1:0] refShift(input logic [W-1:0] a, input int n,
                                            input logic rt, input logic ar);
    if (!rt) return a << n;
    if (!ar) return a >> n;
    return W'($signed(a) >>> n);
  endfunction

  task automatic test_reset();
    apply(16'hFFFF, 16'h0003, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R1 reset clears result", '0);
    apply(16'h1234, 16'h0000, 1'b1, 1'b0, 1'b1, 8'hAB);
    check("R1 reset holds over inputs", '0);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic test_left();
    logic [W-1:0] pats [3] = '{16'h8001, 16'hA5C3, 16'hFFFF};
    foreach (pats[p]) for (int n = 0; n < W; n++) begin
      apply(pats[p], W'(n), 1'b0, n[0], 1'b0, 8'h00);
      check("R3 left shift zero fill", refShift(pats[p], n, 1'b0, 1'b0));
    end
  endtask

  task automatic test_logical_right();
    logic [W-1:0] pats [3] = '{16'h8001, 16'hC35A, 16'h7FFF};
    foreach (pats[p]) for (int n = 0; n < W; n++) begin
      apply(pats[p], W'(n), 1'b1, 1'b0, 1'b0, 8'h00);
      check("R4 logical right", refShift(pats[p], n, 1'b1, 1'b0));
    end
  endtask

  task automatic test_arith_right();
    logic [W-1:0] pats [3] = '{16'h8001, 16'h4F0F, 16'hF00F};
    foreach (pats[p]) for (int n = 0; n < W; n++) begin
      apply(pats[p], W'(n), 1'b1, 1'b1, 1'b0, 8'h00);
      check("R5 arithmetic right", refShift(pats[p], n, 1'b1, 1'b1));
    end
  endtask

  task automatic test_zero_dist();
    for (int m = 0; m < 3; m++) begin
      apply(16'hB6D9, 16'h0000, m != 0, m == 2, 1'b0, 8'h00);
      check("R6 zero distance passthrough", 16'hB6D9);
    end
  endtask

  task automatic test_high_bits_ignored();
    apply(16'h8421, 16'hFFF2, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R2 upper busB ignored left", 16'h1084);
    apply(16'h8421, 16'hABC5, 1'b1, 1'b1, 1'b0, 8'h00);
    check("R2 upper busB ignored arith", 16'hFC21);
    apply(16'h1234, 16'hFFF0, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R2 upper busB ignored zero dist", 16'h1234);
  endtask

  task automatic test_upper_load();
    apply(16'hFFFF, 16'h0005, 1'b0, 1'b0, 1'b1, 8'h07);
    check("R7 upper load 7", 16'h0700);
    apply(16'h1234, 16'hFFFF, 1'b1, 1'b1, 1'b1, 8'hA5);
    check("R7 upper load ignores shift inputs", 16'hA500);
    apply(16'h0000, 16'h000F, 1'b1, 1'b0, 1'b1, 8'hFF);
    check("R7 upper load all ones", 16'hFF00);
  endtask

  task automatic test_timing();
    apply(16'h00F0, 16'h0004, 1'b1, 1'b0, 1'b0, 8'h00);
    check("R8 result after capturing edge", 16'h000F);
    @(negedge clk);
    busA = 16'hFFFF; busB = 16'h0001; shiftRight = 1'b0;
    #2;
    check("R8 result held between edges", 16'h000F);
    @(posedge clk); #1;
    check("R8 result updates at next edge", 16'hFFFE);
  endtask

  initial begin
    test_reset();
    test_left();
    test_logical_right();
    test_arith_right();
    test_zero_dist();
    test_high_bits_ignored();
    test_upper_load();
    test_timing();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

endmodule